// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This block sits between a processor core and its clock tree. A single power-save command carries a mode bit that selects sleep or idle. In idle, only the CPU clock enable is dropped and the peripherals keep running. In sleep, the CPU and peripheral clock enables are both dropped and the main oscillator is told to stop. The one exception is a low-power crystal that has been allowed to keep running through sleep.

While the block is parked, it watches for wake sources:

- an interrupt that is pending, individually enabled and above the current CPU priority;
- a reset event;
- a watchdog timeout.

When it wakes from sleep, it restarts the oscillator that was selected when sleep began. It then keeps the system clocks gated until that oscillator is usable. What "usable" means depends on the oscillator type:

- a crystal waits for the start-up timer;
- a PLL waits for lock;
- an RC or external clock waits a short fixed cycle count;
- a low-power crystal that never stopped needs no wait at all.

A one-cycle wake-complete pulse marks the first cycle in which clocks run again.

Top module: `pwr_save_ctrl`

## Requirements
- R1: During and after reset, the block is running: cpu_clk_en, per_clk_en and osc_run_en are 1 and wake_done is 0.
- R2: A save_req with save_sleep=1, sampled while running, makes cpu_clk_en and per_clk_en 0 from the next cycle.
- R3: A save_req with save_sleep=0, sampled while running, makes cpu_clk_en 0 from the next cycle, while per_clk_en and osc_run_en stay 1. cpu_clk_en is never 1 while per_clk_en is 0.
- R4: Interrupt i wakes the block only when irq_pend[i] and irq_en[i] are both 1 and its 3-bit priority irq_prio[3*i+2:3*i] is strictly greater than cpu_prio. A masked or equal-priority request leaves the block asleep or idle.
- R5: A rst_evt pulse or a wdt_timeout pulse wakes the block from sleep or from idle.
- R6: While asleep, wdt_clk_en equals wdt_en. Outside sleep, wdt_clk_en is 1.
- R7: The oscillator code osc_sel (0 crystal, 1 PLL, 2 RC/external, 3 low-power crystal) is captured when sleep is entered. That captured code alone decides the wake sequence.
- R8: Waking with code 0 (or code 3 with lp_keep=0) holds the clocks gated, with osc_run_en=1, until ost_done is sampled high. Clocks run in the next cycle. pll_lock is ignored.
- R9: Waking with code 1 holds the clocks gated until pll_lock is sampled high. Clocks run in the next cycle. ost_done is ignored.
- R10: Waking with code 2 releases the clocks exactly WAKE_DLY cycles after the cycle in which the wake was sampled, regardless of ost_done and pll_lock.
- R11: With code 3 and lp_keep=1, osc_run_en stays 1 during sleep and the clocks run in the cycle right after the wake is sampled. For all other codes, osc_run_en is 0 in sleep.
- R12: wake_done is 1 for exactly one cycle: the first cycle in which cpu_clk_en is 1 again after a wake.
- R13: A wake from idle restores cpu_clk_en in the next cycle, with no oscillator wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Power-save command strobe |
| save_sleep | input | 1 | Mode bit of the command: 1 sleep, 0 idle |
| irq_pend | input | NIRQ | Pending interrupt requests |
| irq_en | input | NIRQ | Per-request enable bits |
| irq_prio | input | NIRQ*PRIO_W | Priority of each request, packed |
| cpu_prio | input | PRIO_W | Current CPU priority level |
| rst_evt | input | 1 | Reset event wake source |
| wdt_timeout | input | 1 | Watchdog timeout wake source |
| wdt_en | input | 1 | Watchdog enabled |
| ost_done | input | 1 | Oscillator start-up timer expired |
| pll_lock | input | 1 | PLL locked |
| osc_sel | input | 2 | Selected oscillator type code |
| lp_keep | input | 1 | Low-power crystal kept running in sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Main oscillator run enable |
| wdt_clk_en | output | 1 | Watchdog clock run enable |
| wake_done | output | 1 | One-cycle wake-complete pulse |

## Verification
All outputs come from the state register, so a command or wake source sampled at one edge shows up on the outputs right after that same edge.

The cases that take longer are:

- an RC/external wake releases the clocks WAKE_DLY edges after the wake edge;
- a crystal or PLL wake releases them one edge after ost_done or pll_lock is sampled;
- wake_done falls one edge after it rises.

The bench drives and samples 2 ns after each rising edge, so every check reads the state left by the edge just taken. For the waiting cases, it checks that the clocks are still gated on every intermediate edge before checking the release edge. While one ready signal is being waited on, it holds the other one high to show that it has no effect.

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl #(
  parameter int NIRQ     = 4,
  parameter int PRIO_W   = 3,
  parameter int WAKE_DLY = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     save_req,
  input  logic                     save_sleep,
  input  logic [NIRQ-1:0]          irq_pend,
  input  logic [NIRQ-1:0]          irq_en,
  input  logic [NIRQ*PRIO_W-1:0]   irq_prio,
  input  logic [PRIO_W-1:0]        cpu_prio,
  input  logic                     rst_evt,
  input  logic                     wdt_timeout,
  input  logic                     wdt_en,
  input  logic                     ost_done,
  input  logic                     pll_lock,
  input  logic [1:0]               osc_sel,
  input  logic                     lp_keep,
  output logic                     cpu_clk_en,
  output logic                     per_clk_en,
  output logic                     osc_run_en,
  output logic                     wdt_clk_en,
  output logic                     wake_done
);
  localparam int CNT_W = $clog2(WAKE_DLY + 1);
  localparam logic [1:0] OSC_XTAL = 2'd0;
  localparam logic [1:0] OSC_PLL  = 2'd1;
  localparam logic [1:0] OSC_FAST = 2'd2;
  localparam logic [1:0] OSC_LP   = 2'd3;

  typedef enum logic [2:0] {
    S_RUN, S_IDLE, S_SLEEP, S_WAIT_OSC, S_WAIT_LOCK, S_WAIT_DELAY
  } state_t;

  state_t             state, nxt;
  logic [1:0]         osc_hold;
  logic [CNT_W-1:0]   cnt;
  logic               irq_hit, wake, lp_hold;

  always_comb begin
    irq_hit = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_pend[i] && irq_en[i] && (irq_prio[i*PRIO_W +: PRIO_W] > cpu_prio))
        irq_hit = 1'b1;
  end

  assign wake    = irq_hit | rst_evt | wdt_timeout;
  assign lp_hold = (osc_hold == OSC_LP) && lp_keep;

  always_comb begin
    nxt = state;
    unique case (state)
      S_RUN:
        if (save_req) nxt = save_sleep ? S_SLEEP : S_IDLE;
      S_IDLE:
        if (wake) nxt = S_RUN;
      S_SLEEP:
        if (wake) begin
          unique case (osc_hold)
            OSC_XTAL: nxt = S_WAIT_OSC;
            OSC_PLL:  nxt = S_WAIT_LOCK;
            OSC_FAST: nxt = S_WAIT_DELAY;
            default:  nxt = lp_keep ? S_RUN : S_WAIT_OSC;
          endcase
        end
      S_WAIT_OSC:
        if (ost_done) nxt = S_RUN;
      S_WAIT_LOCK:
        if (pll_lock) nxt = S_RUN;
      S_WAIT_DELAY:
        if (cnt == '0) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      osc_hold  <= OSC_XTAL;
      cnt       <= '0;
      wake_done <= 1'b0;
    end else begin
      state     <= nxt;
      wake_done <= (nxt == S_RUN) && (state != S_RUN);
      if (state == S_RUN && save_req && save_sleep)
        osc_hold <= osc_sel;
      if (state == S_SLEEP)
        cnt <= CNT_W'(WAKE_DLY - 1);
      else if (state == S_WAIT_DELAY && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign cpu_clk_en = (state == S_RUN);
  assign per_clk_en = (state == S_RUN) || (state == S_IDLE);
  assign osc_run_en = (state != S_SLEEP) || lp_hold;
  assign wdt_clk_en = (state != S_SLEEP) || wdt_en;
endmodule

module pwr_save_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       save_req,
  input logic       save_sleep,
  input logic       ost_done,
  input logic       wdt_en,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_run_en,
  input logic       wdt_clk_en,
  input logic       wake_done,
  input logic [2:0] st
);
  localparam logic [2:0] C_SLEEP    = 3'd2;
  localparam logic [2:0] C_WAIT_OSC = 3'd3;

  assert_sleep_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && save_sleep && cpu_clk_en) |=> (!cpu_clk_en && !per_clk_en));

  assert_idle_keeps_per_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_sleep && cpu_clk_en) |=> (!cpu_clk_en && per_clk_en && osc_run_en));

  assert_cpu_needs_per_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  assert_wdt_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SLEEP) |-> (wdt_clk_en == wdt_en));

  assert_hold_for_ost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT_OSC && !ost_done) |=> (!cpu_clk_en && osc_run_en));

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

  assert_pulse_with_clock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> cpu_clk_en);
endmodule

bind pwr_save_ctrl pwr_save_chk u_pwr_save_chk (
  .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_sleep(save_sleep),
  .ost_done(ost_done), .wdt_en(wdt_en), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .osc_run_en(osc_run_en), .wdt_clk_en(wdt_clk_en),
  .wake_done(wake_done), .st(state)
);

// File: tb/test_pwr_save_ctrl.sv
module test_pwr_save_ctrl;
  localparam int NIRQ = 4;
  localparam int PW   = 3;
  localparam int DLY  = 4;

  // vector fields: [7:6] osc code, [5] lp_keep, [4] osc_run_en in sleep,
  // [3:2] wait kind (0 none, 1 start-up timer, 2 lock, 3 fixed delay),
  // [1:0] wake source (0 interrupt, 1 watchdog, 2 reset event)
  localparam logic [7:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 2'd1, 2'd0},
    {2'd1, 1'b0, 1'b0, 2'd2, 2'd1},
    {2'd2, 1'b0, 1'b0, 2'd3, 2'd2},
    {2'd3, 1'b1, 1'b1, 2'd0, 2'd0},
    {2'd3, 1'b0, 1'b0, 2'd1, 2'd1},
    {2'd2, 1'b1, 1'b0, 2'd3, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n, save_req, save_sleep, rst_evt, wdt_timeout, wdt_en;
  logic ost_done, pll_lock, lp_keep;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic [NIRQ*PW-1:0] irq_prio;
  logic [PW-1:0] cpu_prio;
  logic [1:0] osc_sel;
  logic cpu_clk_en, per_clk_en, osc_run_en, wdt_clk_en, wake_done;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwr_save_ctrl #(.NIRQ(NIRQ), .PRIO_W(PW), .WAKE_DLY(DLY)) i_pwr_save_ctrl (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_sleep(save_sleep),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
    .rst_evt(rst_evt), .wdt_timeout(wdt_timeout), .wdt_en(wdt_en),
    .ost_done(ost_done), .pll_lock(pll_lock), .osc_sel(osc_sel), .lp_keep(lp_keep),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run_en(osc_run_en),
    .wdt_clk_en(wdt_clk_en), .wake_done(wake_done)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic enter(input logic sleep);
    save_sleep = sleep;
    save_req = 1'b1;
    tick();
    save_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; save_req = 1'b0; save_sleep = 1'b0; rst_evt = 1'b0;
    wdt_timeout = 1'b0; wdt_en = 1'b0; ost_done = 1'b0; pll_lock = 1'b0;
    lp_keep = 1'b0; irq_pend = '0; irq_en = '1; cpu_prio = 3'd2; osc_sel = 2'd0;
    irq_prio = {3'd1, 3'd1, 3'd5, 3'd1};
    #3;
    chk("R1 cpu in reset", cpu_clk_en, 1'b1);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 cpu", cpu_clk_en, 1'b1);
    chk("R1 per", per_clk_en, 1'b1);
    chk("R1 osc", osc_run_en, 1'b1);
    chk("R1 wake_done", wake_done, 1'b0);
    chk("R6 wdt clock outside sleep", wdt_clk_en, 1'b1);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] code, kind, src;
      code = VEC[v][7:6]; lp_keep = VEC[v][5]; kind = VEC[v][3:2]; src = VEC[v][1:0];
      osc_sel = code;
      enter(1'b1);
      chk("R2 cpu gated in sleep", cpu_clk_en, 1'b0);
      chk("R2 per gated in sleep", per_clk_en, 1'b0);
      chk("R11 osc run in sleep", osc_run_en, VEC[v][4]);
      osc_sel = code ^ 2'b01;
      tick();
      chk("R4 no wake without source", cpu_clk_en, 1'b0);
      case (src)
        2'd0: irq_pend = 4'b0010;
        2'd1: wdt_timeout = 1'b1;
        default: rst_evt = 1'b1;
      endcase
      tick();
      irq_pend = '0; wdt_timeout = 1'b0; rst_evt = 1'b0;
      case (kind)
        2'd0: begin
          chk("R11 immediate clocks", cpu_clk_en, 1'b1);
          chk("R12 pulse", wake_done, 1'b1);
        end
        2'd1: begin
          chk("R8 osc on while waiting", osc_run_en, 1'b1);
          pll_lock = 1'b1;
          for (int k = 0; k < 4; k++) begin
            tick();
            chk("R8 R7 gated until start-up timer", cpu_clk_en, 1'b0);
          end
          ost_done = 1'b1;
          tick();
          chk("R8 released", cpu_clk_en, 1'b1);
          chk("R12 pulse", wake_done, 1'b1);
          ost_done = 1'b0; pll_lock = 1'b0;
        end
        2'd2: begin
          ost_done = 1'b1;
          for (int k = 0; k < 4; k++) begin
            tick();
            chk("R9 R7 gated until lock", cpu_clk_en, 1'b0);
          end
          pll_lock = 1'b1;
          tick();
          chk("R9 released", cpu_clk_en, 1'b1);
          chk("R12 pulse", wake_done, 1'b1);
          ost_done = 1'b0; pll_lock = 1'b0;
        end
        default: begin
          chk("R10 gated at wake", per_clk_en, 1'b0);
          for (int k = 0; k < DLY - 1; k++) begin
            tick();
            chk("R10 R7 gated in fixed delay", cpu_clk_en, 1'b0);
          end
          tick();
          chk("R10 released after delay", cpu_clk_en, 1'b1);
          chk("R12 pulse", wake_done, 1'b1);
        end
      endcase
      tick();
      chk("R12 pulse one cycle", wake_done, 1'b0);
      chk("R12 still running", cpu_clk_en, 1'b1);
    end

    lp_keep = 1'b0;
    enter(1'b0);
    chk("R3 cpu gated in idle", cpu_clk_en, 1'b0);
    chk("R3 per runs in idle", per_clk_en, 1'b1);
    chk("R3 osc runs in idle", osc_run_en, 1'b1);
    irq_pend = 4'b0010; irq_en = 4'b1101;
    tick();
    chk("R4 masked request ignored", cpu_clk_en, 1'b0);
    irq_en = '1; irq_prio[5:3] = 3'd2;
    tick();
    chk("R4 equal priority ignored", cpu_clk_en, 1'b0);
    irq_prio[5:3] = 3'd5;
    tick();
    irq_pend = '0;
    chk("R13 idle wake immediate", cpu_clk_en, 1'b1);
    chk("R12 pulse after idle", wake_done, 1'b1);

    enter(1'b0);
    wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R5 watchdog wakes idle", cpu_clk_en, 1'b1);

    osc_sel = 2'd2; wdt_en = 1'b0;
    enter(1'b1);
    chk("R6 wdt clock off in sleep", wdt_clk_en, 1'b0);
    wdt_en = 1'b1;
    #1;
    chk("R6 wdt clock on in sleep", wdt_clk_en, 1'b1);
    rst_evt = 1'b1;
    tick();
    rst_evt = 1'b0;
    chk("R5 reset event wakes sleep", cpu_clk_en, 1'b0);
    for (int k = 0; k < DLY; k++) tick();
    chk("R5 running after reset-event wake", cpu_clk_en, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule